// File: doc/BRIEF.md
# Dual Tick Timer (One-Shot and Periodic)

This block holds two 32-bit tick timers behind a small word-addressed register window. The first timer is a one-shot: once loaded with a nonzero period, it counts down on qualified ticks and fires a single interrupt pulse. It then clears its own period and stays idle until software loads it again. The second timer is periodic: it fires each time its count runs out, reloads the same period and keeps going until it is given zero.

A free-running tick-enable input sets the rate. Every cycle in which it is high counts as one tick. Each timer has a period register, which is read/write, and a remaining-ticks register, which is read-only. All register data is big-endian on the bus. Only full 4-byte accesses are legal. Any other size raises a sticky error flag and changes nothing. The reset input is asynchronous and active-low, and the block releases it internally in step with the clock.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, both period registers and both remaining-ticks registers read as 0, both interrupt outputs are low and the error flag is low.
- R2: Register data is big-endian: `bus_wdata[7:0]` and `bus_rdata[7:0]` carry the most significant byte of the register value, and `bus_wdata[31:24]` and `bus_rdata[31:24]` carry the least significant byte.
- R3: A legal write to offset 0x20 (one-shot) or 0x28 (periodic) stores the value as that timer's period and sets its remaining count to the same value. A legal read of that offset returns the stored period. A remaining-ticks read (offset 0x24 or 0x2C) returns 0 while the period is 0.
- R4: In each cycle with `tick_en` high and a nonzero period, the remaining count drops by one. Without `tick_en`, the count holds.
- R5: A timer expires on the tick that finds its remaining count at 1. Its interrupt output is then high for exactly the one cycle after that clock edge.
- R6: On expiry, the one-shot timer sets both its period and its remaining count to 0 and does not fire again until it is written.
- R7: On expiry, the periodic timer sets its remaining count back to the stored period and continues counting.
- R8: A legal period write cancels any expiry in progress and restarts timing from the write. A write takes priority over a tick in the same cycle. Writing 0 stops the timer.
- R9: An access with `bus_size` other than 4 to any of the four timer offsets sets `err_flag`, which stays high until reset. Such an access changes no timer state, and a read of this kind returns 0.
- R10: Writes to the remaining-ticks offsets, and accesses to any offset other than 0x20, 0x24, 0x28 and 0x2C, change no state. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One timer tick in each cycle it is high |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_size | input | 3 | Access size in bytes; only 4 is legal |
| bus_wdata | input | 32 | Write data, big-endian lanes |
| bus_rdata | output | 32 | Read data for the current read, 0 when none |
| err_flag | output | 1 | Sticky illegal-size error |
| oneshot_irq | output | 1 | One-cycle pulse on one-shot expiry |
| periodic_irq | output | 1 | One-cycle pulse on each periodic expiry |

## Verification
The bench aims at the tick where the count is at 1. A design off by one there would pulse a cycle early or late, or would hold the interrupt for two cycles. It drives a period write and a tick in the same cycle, where a design giving the tick priority would show a remaining count one below the written value. It also checks that the one-shot clears its period on expiry, since a design that failed to clear it would fire again, and that the periodic timer reloads, since a design that failed to reload it would stall. Undersized accesses and byte-lane order are covered too: a design that got these wrong would corrupt a period on a partial write, or return the value byte-reversed.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned TT_ADDR_W  = 6;
  localparam int unsigned TT_DATA_W  = 32;
  localparam int unsigned TT_SIZE_W  = 3;
  localparam int unsigned TT_BYTES   = TT_DATA_W / 8;
  localparam int unsigned TT_NUM     = 2;
  localparam int unsigned TT_BASE    = 32'h20;
  localparam int unsigned TT_STRIDE  = 8;
  localparam int unsigned TT_REM_OFS = 4;
  localparam logic [TT_NUM-1:0] TT_PERIODIC_MASK = 2'b10;

  function automatic logic [TT_DATA_W-1:0] tt_swap(input logic [TT_DATA_W-1:0] v);
    logic [TT_DATA_W-1:0] r;
    for (int b = 0; b < int'(TT_BYTES); b++) begin
      r[8*b +: 8] = v[8*(int'(TT_BYTES)-1-b) +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/tt_timer_core.sv
module tt_timer_core #(
  parameter int unsigned CNT_W    = 32,
  parameter bit          PERIODIC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] remain_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             expire_q, expire_d;
  logic             running, at_end, cnt_en;

  always_comb begin
    running  = (period_q != '0);
    at_end   = (remain_q == CNT_W'(1));
    cnt_en   = load_i | (tick_i & running);
    period_d = period_q;
    remain_d = remain_q;
    expire_d = 1'b0;
    if (load_i) begin
      period_d = load_val_i;
      remain_d = load_val_i;
    end else if (tick_i && running) begin
      if (at_end) begin
        expire_d = 1'b1;
        if (PERIODIC) begin
          remain_d = period_q;
        end else begin
          period_d = '0;
          remain_d = '0;
        end
      end else begin
        remain_d = remain_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      remain_q <= '0;
      expire_q <= 1'b0;
    end else begin
      if (cnt_en) begin
        period_q <= period_d;
        remain_q <= remain_d;
      end
      expire_q <= expire_d;
    end
  end

  assign period_o = period_q;
  assign remain_o = running ? remain_q : '0;
  assign expire_o = expire_q;

  AST_IRQ_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |-> $past(tick_i)); // R5
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(remain_q)); // R4
  AST_LOAD_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (remain_q == $past(load_val_i)) && !expire_q); // R8

  if (PERIODIC) begin : g_periodic_chk
    AST_PERIODIC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_q |-> (remain_q == period_q) && (period_q != '0)); // R7
  end else begin : g_oneshot_chk
    AST_ONESHOT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_q |-> (period_q == '0) && (remain_o == '0)); // R6
  end
endmodule

// File: rtl/tt_bus_decode.sv
module tt_bus_decode
  import tick_timer_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              valid_i,
  input  logic                              write_i,
  input  logic [TT_ADDR_W-1:0]              addr_i,
  input  logic [TT_SIZE_W-1:0]              size_i,
  input  logic [TT_DATA_W-1:0]              wdata_i,
  input  logic [TT_NUM-1:0][TT_DATA_W-1:0]  period_i,
  input  logic [TT_NUM-1:0][TT_DATA_W-1:0]  remain_i,
  output logic [TT_NUM-1:0]                 load_o,
  output logic [TT_DATA_W-1:0]              load_val_o,
  output logic [TT_DATA_W-1:0]              rdata_o,
  output logic                              err_o
);
  logic [TT_NUM-1:0] hit_per, hit_rem;
  logic              in_map, size_ok, rd_ok, wr_ok, set_err;
  logic              err_q;

  for (genvar g = 0; g < int'(TT_NUM); g++) begin : g_hit
    assign hit_per[g] = (addr_i == TT_ADDR_W'(TT_BASE + g*TT_STRIDE));
    assign hit_rem[g] = (addr_i == TT_ADDR_W'(TT_BASE + g*TT_STRIDE + TT_REM_OFS));
  end

  always_comb begin
    in_map     = (|hit_per) | (|hit_rem);
    size_ok    = (size_i == TT_SIZE_W'(TT_BYTES));
    rd_ok      = valid_i & ~write_i & size_ok;
    wr_ok      = valid_i & write_i & size_ok;
    set_err    = valid_i & in_map & ~size_ok;
    load_o     = wr_ok ? hit_per : '0;
    load_val_o = tt_swap(wdata_i);
    rdata_o    = '0;
    if (rd_ok) begin
      for (int t = 0; t < int'(TT_NUM); t++) begin
        if (hit_per[t]) rdata_o = tt_swap(period_i[t]);
        if (hit_rem[t]) rdata_o = tt_swap(remain_i[t]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (set_err) begin
      err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R9
  AST_BAD_SIZE_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_map && !size_ok) |=> err_q); // R9
  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !write_i && !size_ok) |-> (rdata_o == '0)); // R9
  AST_SINGLE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_o)); // R10
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import tick_timer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [TT_ADDR_W-1:0] bus_addr,
  input  logic [TT_SIZE_W-1:0] bus_size,
  input  logic [TT_DATA_W-1:0] bus_wdata,
  output logic [TT_DATA_W-1:0] bus_rdata,
  output logic                 err_flag,
  output logic                 oneshot_irq,
  output logic                 periodic_irq
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [TT_NUM-1:0][TT_DATA_W-1:0] period_w, remain_w;
  logic [TT_NUM-1:0]                load_w, expire_w;
  logic [TT_DATA_W-1:0]             load_val_w;

  tt_bus_decode u_decode (
    .clk_i      (clk),
    .rst_ni     (rst_sync),
    .valid_i    (bus_valid),
    .write_i    (bus_write),
    .addr_i     (bus_addr),
    .size_i     (bus_size),
    .wdata_i    (bus_wdata),
    .period_i   (period_w),
    .remain_i   (remain_w),
    .load_o     (load_w),
    .load_val_o (load_val_w),
    .rdata_o    (bus_rdata),
    .err_o      (err_flag)
  );

  for (genvar g = 0; g < int'(TT_NUM); g++) begin : g_timer
    tt_timer_core #(
      .CNT_W    (TT_DATA_W),
      .PERIODIC (TT_PERIODIC_MASK[g])
    ) u_core (
      .clk_i      (clk),
      .rst_ni     (rst_sync),
      .tick_i     (tick_en),
      .load_i     (load_w[g]),
      .load_val_i (load_val_w),
      .period_o   (period_w[g]),
      .remain_o   (remain_w[g]),
      .expire_o   (expire_w[g])
    );
  end

  assign oneshot_irq  = expire_w[0];
  assign periodic_irq = expire_w[1];
endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, bus_valid, bus_write;
  logic [5:0]  bus_addr;
  logic [2:0]  bus_size;
  logic [31:0] bus_wdata, bus_rdata;
  logic        err_flag, oneshot_irq, periodic_irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_per [2];
  logic [31:0] m_rem [2];
  bit          m_irq [2];
  bit          m_err;
  logic [31:0] obs_rd;
  logic        obs_irq0, obs_irq1;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .err_flag(err_flag),
    .oneshot_irq(oneshot_irq), .periodic_irq(periodic_irq)
  );

  function automatic logic [31:0] be(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] exp_rd(input bit v, input bit w, input logic [5:0] a, input logic [2:0] s);
    if (!(v && !w && s == 3'd4)) return 32'h0;
    case (a)
      6'h20: return be(m_per[0]);
      6'h24: return be(m_per[0] != 0 ? m_rem[0] : 32'h0);
      6'h28: return be(m_per[1]);
      6'h2C: return be(m_per[1] != 0 ? m_rem[1] : 32'h0);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [5:0] a, input logic [2:0] s);
    if (a == 6'h20 || a == 6'h28 || a == 6'h24 || a == 6'h2C)
      return (s != 3'd4) ? "R9" : ((a[2]) ? "R4" : "R3");
    return "R10";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update(input bit v, input bit w, input logic [5:0] a,
                              input logic [2:0] s, input logic [31:0] d, input bit t);
    for (int i = 0; i < 2; i++) begin
      m_irq[i] = 0;
      if (v && w && s == 3'd4 && a == 6'(32'h20 + 8*i)) begin
        m_per[i] = be(d);
        m_rem[i] = be(d);
      end else if (t && m_per[i] != 0) begin
        if (m_rem[i] == 1) begin
          m_irq[i] = 1;
          if (i == 1) m_rem[i] = m_per[i];
          else begin m_per[i] = 0; m_rem[i] = 0; end
        end else m_rem[i] = m_rem[i] - 1;
      end
    end
    if (v && s != 3'd4 && (a == 6'h20 || a == 6'h24 || a == 6'h28 || a == 6'h2C)) m_err = 1;
  endtask

  task automatic step(input bit v, input bit w, input logic [5:0] a,
                      input logic [2:0] s, input logic [31:0] d, input bit t);
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_size = s; bus_wdata = d; tick_en = t;
    #1;
    obs_rd = bus_rdata; obs_irq0 = oneshot_irq; obs_irq1 = periodic_irq;
    chk("R5", {31'h0, oneshot_irq}, {31'h0, m_irq[0]});
    chk("R5", {31'h0, periodic_irq}, {31'h0, m_irq[1]});
    chk("R9", {31'h0, err_flag}, {31'h0, m_err});
    if (v && !w) chk(rd_tag(a, s), bus_rdata, exp_rd(v, w, a, s));
    @(posedge clk);
    model_update(v, w, a, s, d, t);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] val, input bit t);
    step(1, 1, a, 3'd4, be(val), t);
  endtask

  task automatic rd(input logic [5:0] a);
    step(1, 0, a, 3'd4, 32'h0, 0);
  endtask

  task automatic idle(input bit t);
    step(0, 0, 6'h0, 3'd0, 32'h0, t);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pulses;
    void'($urandom(32'd1234));
    rst_n = 0; tick_en = 0; bus_valid = 0; bus_write = 0;
    bus_addr = 0; bus_size = 0; bus_wdata = 0;
    for (int i = 0; i < 2; i++) begin m_per[i] = 0; m_rem[i] = 0; m_irq[i] = 0; end
    m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(6'h20); chk("R1", obs_rd, 32'h0);
    rd(6'h24); chk("R1", obs_rd, 32'h0);
    rd(6'h28); chk("R1", obs_rd, 32'h0);
    rd(6'h2C); chk("R1", obs_rd, 32'h0);
    chk("R1", {30'h0, obs_irq0, obs_irq1}, 32'h0);
    chk("R1", {31'h0, err_flag}, 32'h0);

    // R2: byte lanes
    step(1, 1, 6'h20, 3'd4, 32'h04030201, 0);
    rd(6'h20); chk("R2", obs_rd, 32'h04030201);
    rd(6'h24); chk("R2", obs_rd, 32'h04030201);
    wr(6'h20, 0, 0);
    rd(6'h24); chk("R3", obs_rd, 32'h0);

    // R6: one-shot expires after 3 ticks, then clears
    wr(6'h20, 3, 0);
    idle(1); idle(0); idle(1);
    rd(6'h24); chk("R4", obs_rd, be(32'd1));
    idle(1);
    idle(0); chk("R5", {31'h0, obs_irq0}, 32'h1);
    idle(1); chk("R5", {31'h0, obs_irq0}, 32'h0);
    rd(6'h20); chk("R6", obs_rd, 32'h0);
    pulses = 0;
    for (int k = 0; k < 6; k++) begin idle(1); pulses += obs_irq0; end
    chk("R6", pulses, 0);

    // R7: periodic reloads
    wr(6'h28, 2, 0);
    pulses = 0;
    for (int k = 0; k < 7; k++) begin idle(1); pulses += obs_irq1; end
    chk("R7", pulses, 3);
    rd(6'h28); chk("R7", obs_rd, be(32'd2));

    // R8: restart on write, write beats tick, zero stops
    wr(6'h28, 5, 0);
    idle(1); idle(1);
    wr(6'h28, 5, 1);
    rd(6'h2C); chk("R8", obs_rd, be(32'd5));
    wr(6'h28, 0, 1);
    pulses = 0;
    for (int k = 0; k < 8; k++) begin idle(1); pulses += obs_irq1; end
    chk("R8", pulses, 0);

    // R9: illegal size
    step(1, 1, 6'h28, 3'd2, be(32'd7), 0);
    idle(0); chk("R9", {31'h0, err_flag}, 32'h1);
    rd(6'h28); chk("R9", obs_rd, 32'h0);
    step(1, 0, 6'h28, 3'd1, 32'h0, 0); chk("R9", obs_rd, 32'h0);

    // R10: remaining-ticks and unmapped writes ignored
    wr(6'h20, 9, 0);
    wr(6'h24, 2, 0);
    wr(6'h30, 4, 0);
    rd(6'h24); chk("R10", obs_rd, be(32'd9));
    rd(6'h20); chk("R10", obs_rd, be(32'd9));
    rd(6'h10); chk("R10", obs_rd, 32'h0);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      bit v, w, t;
      logic [5:0] a;
      logic [2:0] s;
      logic [31:0] val;
      int r;
      v = ($urandom % 10) < 4;
      w = $urandom % 2;
      t = $urandom % 2;
      r = $urandom % 6;
      a = (r < 4) ? 6'(32'h20 + 4*r) : 6'($urandom % 64);
      s = (($urandom % 8) == 0) ? 3'($urandom % 8) : 3'd4;
      val = (($urandom % 4) == 0) ? 32'h0 : 32'(1 + $urandom % 12);
      if (($urandom % 50) == 0) val = $urandom;
      step(v, w, a, s, be(val), t);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule